// File: doc/BRIEF.md
# Beam Destination and Mastership Arbiter

This block picks where the beam extracted from the injector goes on each super-cycle. A single-cycle start pulse marks the super-cycle boundary. On that pulse the block combines four things into a registered destination code and a per-batch kill mask: whether the sequencer holds mastership, the user request, the interlock and transfer-line inhibit status, and the transfer-line dump requests with their in-place indications. Batches flagged in the kill mask are cut upstream and sent to the upstream dump, but their injection timing still fires.

A fill request names a ring, an RF bucket and a batch count. It is checked for range when it arrives. If it is valid it is held pending and used by the next super-cycle start, then dropped.

Mastership is a single state bit with a request/response handshake. A request to take or release it is granted only while the user request is absent and the allow bit is set. The block answers every request with an acknowledge pulse or an error pulse.

Top module: `beam_dest_arbiter`

## Requirements
- R1: When `interlock_ok` is low or `user_req` is low at the start pulse, the destination is spare (code 0) and all kill bits are set.
- R2: A transfer-line destination is issued only when master, a fill request is pending and `line_inhibit` is low. Ring 0 gives code 2 and ring 1 gives code 3. Kill bit i is set exactly when i is not less than the requested batch count.
- R3: When not master, a dump request bit (bit 0 line 1, bit 1 line 2) is granted only if the matching `dump_in_place` bit is set. The line 1 dump takes priority. Granted dumps give code 4 (line 1) or code 5 (line 2) with no kill bits. Dump requests are ignored while master.
- R4: When not master and no dump is granted, with interlocks good and the user request present, the destination is the internal dump (code 1) with no kill bits.
- R5: When master and either no fill request is pending or `line_inhibit` is high, the destination is the internal dump (code 1) with all kill bits set, so the cycle plays without beam.
- R6: A mastership request (`mst_req`, target in `mst_want`) is granted only when `user_req` is low and `mst_allow` is high. A grant gives a one-cycle `mst_ack` and sets `is_master` to `mst_want`. Otherwise a one-cycle `mst_err` is raised and `is_master` keeps its value.
- R7: A fill request with a batch count of 0 or above 4, or a bucket of 35640 or more, raises `fill_err` for one cycle and is not stored.
- R8: A pending fill request is cleared by every start pulse. A valid request that arrives in the same cycle as a start pulse is kept for the following super-cycle.
- R9: Outputs update one clock after the start pulse, with `dest_valid` high for that one cycle. They hold until the next start. After reset they are all zero and `is_master` is low.
- R10: `out_ring` and `out_bucket` carry the consumed request's ring and bucket with a transfer-line destination, and are zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | Super-cycle start pulse |
| user_req | input | 1 | User request present |
| interlock_ok | input | 1 | High when no abnormal interlock |
| line_inhibit | input | 1 | Transfer-line inhibit active |
| dump_req | input | 2 | Dump request, bit 0 line 1, bit 1 line 2 |
| dump_in_place | input | 2 | Dump target in place, per line |
| mst_req | input | 1 | Mastership change request pulse |
| mst_want | input | 1 | Requested mastership state |
| mst_allow | input | 1 | Mastership change allowed |
| fill_valid | input | 1 | Fill request pulse |
| fill_ring | input | 1 | Ring, 0 ring 1, 1 ring 2 |
| fill_bucket | input | 16 | RF bucket number |
| fill_batches | input | 3 | Batch count |
| is_master | output | 1 | Sequencer holds mastership |
| mst_ack | output | 1 | Mastership request granted |
| mst_err | output | 1 | Mastership request refused |
| fill_err | output | 1 | Fill request rejected |
| dest_valid | output | 1 | New decision this cycle |
| dest | output | 3 | Destination code |
| kill_mask | output | 4 | Per-batch kill flags |
| out_ring | output | 1 | Ring of consumed request |
| out_bucket | output | 16 | Bucket of consumed request |

## Verification
A fill request and a super-cycle start pulse can arrive in the same clock. In that case the start must not consume or clear the new request, and must decide from whatever was pending before. The bench drives `fill_valid` and `cycle_start` together while master with nothing pending. It expects the internal dump with all batches killed on that start. On the following start it expects the line destination and mask named by the colliding request.

// File: rtl/beam_dest_pkg.sv
package beam_dest_pkg;
  typedef enum logic [2:0] {
    DEST_SPARE      = 3'd0,
    DEST_INT_DUMP   = 3'd1,
    DEST_LINE1      = 3'd2,
    DEST_LINE2      = 3'd3,
    DEST_LINE1_DUMP = 3'd4,
    DEST_LINE2_DUMP = 3'd5
  } dest_e;
endpackage

// File: rtl/fill_req_latch.sv
module fill_req_latch #(
  parameter int unsigned BATCHES   = 4,
  parameter int unsigned BUCKET_W  = 16,
  parameter int unsigned N_BUCKETS = 35640,
  parameter int unsigned CNT_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cycle_start,
  input  logic                fill_valid,
  input  logic                fill_ring,
  input  logic [BUCKET_W-1:0] fill_bucket,
  input  logic [CNT_W-1:0]    fill_batches,
  output logic                pend_valid,
  output logic                pend_ring,
  output logic [BUCKET_W-1:0] pend_bucket,
  output logic [CNT_W-1:0]    pend_batches,
  output logic                fill_err
);
  localparam logic [CNT_W-1:0]    MAX_CNT = CNT_W'(BATCHES);
  localparam logic [BUCKET_W-1:0] BKT_LIM = BUCKET_W'(N_BUCKETS);

  logic req_ok, load_en;
  logic valid_n, err_n;

  always_comb begin
    req_ok  = (fill_batches != '0) && (fill_batches <= MAX_CNT) && (fill_bucket < BKT_LIM);
    load_en = fill_valid && req_ok;
    err_n   = fill_valid && !req_ok;
    valid_n = pend_valid;
    if (load_en)          valid_n = 1'b1;
    else if (cycle_start) valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      fill_err   <= 1'b0;
    end else begin
      pend_valid <= valid_n;
      fill_err   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_ring    <= 1'b0;
      pend_bucket  <= '0;
      pend_batches <= '0;
    end else if (load_en) begin
      pend_ring    <= fill_ring;
      pend_bucket  <= fill_bucket;
      pend_batches <= fill_batches;
    end
  end

  assert_err_needs_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> $past(fill_valid));
  assert_start_clears_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && !fill_valid) |=> !pend_valid);
  assert_pending_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (pend_batches != '0 && pend_batches <= MAX_CNT && pend_bucket < BKT_LIM));
endmodule

// File: rtl/mastership_ctrl.sv
module mastership_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mst_req,
  input  logic mst_want,
  input  logic mst_allow,
  input  logic user_req,
  output logic is_master,
  output logic mst_ack,
  output logic mst_err
);
  logic grant, master_n;

  always_comb begin
    grant    = mst_req && mst_allow && !user_req;
    master_n = grant ? mst_want : is_master;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_master <= 1'b0;
      mst_ack   <= 1'b0;
      mst_err   <= 1'b0;
    end else begin
      is_master <= master_n;
      mst_ack   <= grant;
      mst_err   <= mst_req && !grant;
    end
  end

  assert_ack_err_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mst_ack, mst_err}));
  assert_change_only_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(is_master) |-> mst_ack);
  assert_ack_conditions_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mst_ack |-> $past(!user_req && mst_allow));
endmodule

// File: rtl/dest_resolver.sv
module dest_resolver
  import beam_dest_pkg::*;
#(
  parameter int unsigned BATCHES = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic               is_master,
  input  logic               user_req,
  input  logic               interlock_ok,
  input  logic               line_inhibit,
  input  logic [1:0]         dump_req,
  input  logic [1:0]         dump_in_place,
  input  logic               pend_valid,
  input  logic               pend_ring,
  input  logic [CNT_W-1:0]   pend_batches,
  output dest_e              dest,
  output logic [BATCHES-1:0] kill_mask,
  output logic               use_fill
);
  logic [BATCHES-1:0] keep;

  for (genvar gi = 0; gi < BATCHES; gi++) begin : g_keep
    assign keep[gi] = (CNT_W'(gi) < pend_batches);
  end

  always_comb begin
    dest      = DEST_SPARE;
    kill_mask = '1;
    use_fill  = 1'b0;
    if (!interlock_ok || !user_req) begin
      dest      = DEST_SPARE;
      kill_mask = '1;
    end else if (is_master) begin
      if (pend_valid && !line_inhibit) begin
        dest      = pend_ring ? DEST_LINE2 : DEST_LINE1;
        kill_mask = ~keep;
        use_fill  = 1'b1;
      end else begin
        dest      = DEST_INT_DUMP;
        kill_mask = '1;
      end
    end else begin
      kill_mask = '0;
      if (dump_req[0] && dump_in_place[0])      dest = DEST_LINE1_DUMP;
      else if (dump_req[1] && dump_in_place[1]) dest = DEST_LINE2_DUMP;
      else                                      dest = DEST_INT_DUMP;
    end
  end
endmodule

// File: rtl/beam_dest_arbiter.sv
module beam_dest_arbiter
  import beam_dest_pkg::*;
#(
  parameter int unsigned BATCHES   = 4,
  parameter int unsigned BUCKET_W  = 16,
  parameter int unsigned N_BUCKETS = 35640
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cycle_start,
  input  logic                  user_req,
  input  logic                  interlock_ok,
  input  logic                  line_inhibit,
  input  logic [1:0]            dump_req,
  input  logic [1:0]            dump_in_place,
  input  logic                  mst_req,
  input  logic                  mst_want,
  input  logic                  mst_allow,
  input  logic                  fill_valid,
  input  logic                  fill_ring,
  input  logic [BUCKET_W-1:0]   fill_bucket,
  input  logic [$clog2(BATCHES+1)-1:0] fill_batches,
  output logic                  is_master,
  output logic                  mst_ack,
  output logic                  mst_err,
  output logic                  fill_err,
  output logic                  dest_valid,
  output logic [2:0]            dest,
  output logic [BATCHES-1:0]    kill_mask,
  output logic                  out_ring,
  output logic [BUCKET_W-1:0]   out_bucket
);
  localparam int unsigned CNT_W = $clog2(BATCHES + 1);

  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic                pend_valid, pend_ring, use_fill;
  logic [BUCKET_W-1:0] pend_bucket;
  logic [CNT_W-1:0]    pend_batches;
  dest_e               dest_n;
  logic [BATCHES-1:0]  kill_n;

  mastership_ctrl u_mst (
    .clk(clk), .rst_n(rst_q), .mst_req(mst_req), .mst_want(mst_want),
    .mst_allow(mst_allow), .user_req(user_req), .is_master(is_master),
    .mst_ack(mst_ack), .mst_err(mst_err)
  );

  fill_req_latch #(.BATCHES(BATCHES), .BUCKET_W(BUCKET_W), .N_BUCKETS(N_BUCKETS), .CNT_W(CNT_W)) u_fill (
    .clk(clk), .rst_n(rst_q), .cycle_start(cycle_start), .fill_valid(fill_valid),
    .fill_ring(fill_ring), .fill_bucket(fill_bucket), .fill_batches(fill_batches),
    .pend_valid(pend_valid), .pend_ring(pend_ring), .pend_bucket(pend_bucket),
    .pend_batches(pend_batches), .fill_err(fill_err)
  );

  dest_resolver #(.BATCHES(BATCHES), .CNT_W(CNT_W)) u_res (
    .is_master(is_master), .user_req(user_req), .interlock_ok(interlock_ok),
    .line_inhibit(line_inhibit), .dump_req(dump_req), .dump_in_place(dump_in_place),
    .pend_valid(pend_valid), .pend_ring(pend_ring), .pend_batches(pend_batches),
    .dest(dest_n), .kill_mask(kill_n), .use_fill(use_fill)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) dest_valid <= 1'b0;
    else        dest_valid <= cycle_start;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      dest       <= '0;
      kill_mask  <= '0;
      out_ring   <= 1'b0;
      out_bucket <= '0;
    end else if (cycle_start) begin
      dest       <= dest_n;
      kill_mask  <= kill_n;
      out_ring   <= use_fill ? pend_ring : 1'b0;
      out_bucket <= use_fill ? pend_bucket : '0;
    end
  end

  assert_spare_kills_all_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (dest_valid && dest == DEST_SPARE) |-> (kill_mask == '1));
  assert_line_needs_master_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (dest_valid && (dest == DEST_LINE1 || dest == DEST_LINE2))
      |-> $past(is_master && !line_inhibit && interlock_ok && user_req));
  assert_dump_in_place_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (dest_valid && dest == DEST_LINE1_DUMP) |-> $past(dump_in_place[0] && !is_master));
  assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_q)
    dest_valid |-> (dest <= 3'd5));
  assert_valid_after_start_R9: assert property (@(posedge clk) disable iff (!rst_q)
    cycle_start |=> dest_valid);
  assert_hold_between_starts_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !dest_valid |-> $stable(dest));
  assert_echo_only_on_line_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (dest_valid && dest != DEST_LINE1 && dest != DEST_LINE2) |-> (out_bucket == '0));
endmodule

// File: tb/beam_dest_arbiter_test.sv
module beam_dest_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cycle_start = 1'b0, user_req = 1'b0, interlock_ok = 1'b1, line_inhibit = 1'b0;
  logic [1:0]  dump_req = 2'b00, dump_in_place = 2'b00;
  logic        mst_req = 1'b0, mst_want = 1'b0, mst_allow = 1'b0;
  logic        fill_valid = 1'b0, fill_ring = 1'b0;
  logic [15:0] fill_bucket = 16'd0;
  logic [2:0]  fill_batches = 3'd0;
  logic        is_master, mst_ack, mst_err, fill_err, dest_valid, out_ring;
  logic [2:0]  dest;
  logic [3:0]  kill_mask;
  logic [15:0] out_bucket;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  beam_dest_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .user_req(user_req),
    .interlock_ok(interlock_ok), .line_inhibit(line_inhibit), .dump_req(dump_req),
    .dump_in_place(dump_in_place), .mst_req(mst_req), .mst_want(mst_want),
    .mst_allow(mst_allow), .fill_valid(fill_valid), .fill_ring(fill_ring),
    .fill_bucket(fill_bucket), .fill_batches(fill_batches), .is_master(is_master),
    .mst_ack(mst_ack), .mst_err(mst_err), .fill_err(fill_err), .dest_valid(dest_valid),
    .dest(dest), .kill_mask(kill_mask), .out_ring(out_ring), .out_bucket(out_bucket)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // start pulse, then compare the decision at the following falling edge
  task automatic start_and_check(input string tag, input logic [2:0] e_dest, input logic [3:0] e_kill);
    @(negedge clk) cycle_start = 1'b1;
    @(negedge clk) cycle_start = 1'b0;
    chk({tag, " valid"}, dest_valid, 1);
    chk({tag, " dest"}, dest, e_dest);
    chk({tag, " kill"}, kill_mask, e_kill);
  endtask

  task automatic mastership(input string tag, input logic want, input logic e_ack, input logic e_master);
    @(negedge clk) begin mst_req = 1'b1; mst_want = want; end
    @(negedge clk) mst_req = 1'b0;
    chk({tag, " ack"}, mst_ack, e_ack);
    chk({tag, " err"}, mst_err, !e_ack);
    chk({tag, " master"}, is_master, e_master);
  endtask

  task automatic send_fill(input string tag, input logic ring, input logic [15:0] bkt,
                           input logic [2:0] n, input logic e_err);
    @(negedge clk) begin
      fill_valid = 1'b1; fill_ring = ring; fill_bucket = bkt; fill_batches = n;
    end
    @(negedge clk) fill_valid = 1'b0;
    chk({tag, " fill_err"}, fill_err, e_err);
  endtask

  task automatic t_reset();
    chk("R9 reset dest", dest, 0);
    chk("R9 reset valid", dest_valid, 0);
    chk("R9 reset kill", kill_mask, 0);
    chk("R9 reset master", is_master, 0);
  endtask

  task automatic t_not_master();
    user_req = 1'b1;
    start_and_check("R4 default", 3'd1, 4'h0);
    @(negedge clk);
    chk("R9 valid drops", dest_valid, 0);
    chk("R9 dest held", dest, 1);
    dump_req = 2'b01; dump_in_place = 2'b00;
    start_and_check("R3 not in place", 3'd1, 4'h0);
    dump_in_place = 2'b01;
    start_and_check("R3 line1 dump", 3'd4, 4'h0);
    dump_req = 2'b11; dump_in_place = 2'b11;
    start_and_check("R3 priority", 3'd4, 4'h0);
    dump_req = 2'b10; dump_in_place = 2'b10;
    start_and_check("R3 line2 dump", 3'd5, 4'h0);
    chk("R10 no echo", out_bucket, 0);
    dump_req = 2'b00; dump_in_place = 2'b00;
  endtask

  task automatic t_spare();
    interlock_ok = 1'b0;
    start_and_check("R1 interlock", 3'd0, 4'hF);
    interlock_ok = 1'b1; user_req = 1'b0;
    start_and_check("R1 no user", 3'd0, 4'hF);
    user_req = 1'b1;
  endtask

  task automatic t_mastership();
    mst_allow = 1'b1; user_req = 1'b1;
    mastership("R6 user active", 1'b1, 1'b0, 1'b0);
    user_req = 1'b0; mst_allow = 1'b0;
    mastership("R6 not allowed", 1'b1, 1'b0, 1'b0);
    mst_allow = 1'b1;
    mastership("R6 take", 1'b1, 1'b1, 1'b1);
    user_req = 1'b1;
  endtask

  task automatic t_master_fill();
    dump_req = 2'b01; dump_in_place = 2'b01;
    start_and_check("R5 no pending", 3'd1, 4'hF);
    dump_req = 2'b00; dump_in_place = 2'b00;
    send_fill("R7 zero batches", 1'b0, 16'd10, 3'd0, 1'b1);
    send_fill("R7 bucket limit", 1'b0, 16'd35640, 3'd2, 1'b1);
    send_fill("R7 five batches", 1'b0, 16'd10, 3'd5, 1'b1);
    start_and_check("R7 nothing stored", 3'd1, 4'hF);
    send_fill("R2 good fill", 1'b0, 16'd35639, 3'd2, 1'b0);
    start_and_check("R2 line1", 3'd2, 4'b1100);
    chk("R10 bucket", out_bucket, 35639);
    chk("R10 ring", out_ring, 0);
    start_and_check("R8 consumed", 3'd1, 4'hF);
    send_fill("R5 fill", 1'b1, 16'd100, 3'd4, 1'b0);
    line_inhibit = 1'b1;
    start_and_check("R5 inhibited", 3'd1, 4'hF);
    line_inhibit = 1'b0;
    start_and_check("R8 cleared by inhibited start", 3'd1, 4'hF);
  endtask

  task automatic t_collision();
    @(negedge clk) begin
      cycle_start = 1'b1; fill_valid = 1'b1; fill_ring = 1'b1;
      fill_bucket = 16'd7; fill_batches = 3'd1;
    end
    @(negedge clk) begin cycle_start = 1'b0; fill_valid = 1'b0; end
    chk("R8 collision old decision", dest, 1);
    chk("R8 collision old kill", kill_mask, 4'hF);
    start_and_check("R8 collision kept", 3'd3, 4'b1110);
    chk("R10 ring2", out_ring, 1);
    chk("R10 bucket7", out_bucket, 7);
  endtask

  task automatic t_release();
    user_req = 1'b0;
    mastership("R6 release", 1'b0, 1'b1, 1'b0);
    user_req = 1'b1;
    start_and_check("R4 after release", 3'd1, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_not_master();
    t_spare();
    t_mastership();
    t_master_fill();
    t_collision();
    t_release();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule